// File: doc/BRIEF.md
# Status Flags and Relative Branch Unit

This block keeps the processor's eight condition flags and resolves relative control transfers. Each cycle at most one operation arrives, tagged by a kind code. Some operations change the flags: forcing one flag high or low by index, or capturing one bit of a data register into the transfer flag. The bit-load path is combinational. It returns the supplied register value with one bit position overwritten by the transfer flag.

For conditional branches, the unit tests the selected condition against the current flags. It then produces the next program counter and the cycle cost. Either a single flag is compared with a wanted polarity, or the signed comparison term (negative XOR overflow) is compared with it. A taken branch adds a sign-extended 7-bit offset plus one to the program counter; a not-taken branch just steps by one. The unconditional relative jump always moves, using a 12-bit signed offset. Branch results appear on registered outputs one clock after the operation.

Top module: `flag_branch_unit`

## Requirements
- R1: After reset, `sreg` is 8'h00 and `br_valid` is 0.
- R2: Flag set (kind 1) writes 1 to `sreg[op_bit]` and leaves the other seven bits unchanged. The flag layout is: bit 7 interrupt enable, 6 transfer (T), 5 half carry, 4 sign, 3 overflow, 2 negative, 1 zero, 0 carry.
- R3: Flag clear (kind 2) writes 0 to `sreg[op_bit]` and leaves the other bits unchanged.
- R4: Bit store (kind 3) copies `reg_in[op_bit]` into T (`sreg[6]`) and leaves the other flags unchanged.
- R5: `reg_out` always equals `reg_in` with bit `op_bit` replaced by the current T. Bit load (kind 4) does not alter `sreg`.
- R6: Conditional branch (kind 5) with `op_sel[3]`=0 is taken exactly when `sreg[op_sel[2:0]]` equals `op_pol`.
- R7: Conditional branch with `op_sel[3]`=1 is taken exactly when `sreg[2]` XOR `sreg[3]` equals `op_pol`. Polarity 0 gives signed greater-or-equal; polarity 1 gives signed less-than.
- R8: A taken conditional branch gives `br_pc` = `pc_in` + signext(`ofs_in[6:0]`) + 1. A not-taken branch gives `pc_in` + 1. Both wrap modulo 2^16.
- R9: `br_cycles` is 1 for a not-taken branch and 2 for a taken one.
- R10: Relative jump (kind 6) is always taken, costs 2 cycles, and gives `br_pc` = `pc_in` + signext(`ofs_in[11:0]`) + 1.
- R11: `br_valid` is 1 exactly in the cycle after an accepted kind 5 or kind 6 operation. Branches and jumps do not alter `sreg`.
- R12: When `op_valid` is 0, or the kind is 0 or 7, `sreg` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 3 | 0 none, 1 set, 2 clear, 3 bit store, 4 bit load, 5 branch, 6 jump, 7 none |
| op_bit | input | 3 | Flag index or register bit index |
| op_sel | input | 4 | Branch condition: [3] signed term, [2:0] flag index |
| op_pol | input | 1 | Condition value that makes the branch taken |
| reg_in | input | 8 | Register value for bit store and bit load |
| pc_in | input | 16 | Program counter of the branch |
| ofs_in | input | 12 | Raw offset field |
| sreg | output | 8 | Status flags |
| reg_out | output | 8 | Register value after bit load |
| br_valid | output | 1 | Branch result valid |
| br_taken | output | 1 | Branch taken |
| br_cycles | output | 2 | Cycle cost of the branch |
| br_pc | output | 16 | Next program counter |

## Verification
All 256 flag patterns are built by per-bit set and clear operations. Each pattern is then tried with every single-flag condition and the signed condition, under both polarities. This separates a wrong flag index or an inverted polarity from a signed term built from the wrong bits. Program counters and offsets change with the pattern so that both offset signs, 16-bit wraparound, and the 7-bit versus 12-bit extension are exercised. Bit store and bit load sweep all bit positions against register values whose chosen bit differs from T, and idle or reserved operations are checked to leave the flags alone.

// File: rtl/flag_branch_pkg.sv
package flag_branch_pkg;
  localparam int SR_W  = 8;
  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;
  localparam int FLG_T = 6;
  localparam int FLG_I = 7;

  typedef enum logic [2:0] {
    K_NOP  = 3'd0,
    K_FSET = 3'd1,
    K_FCLR = 3'd2,
    K_BST  = 3'd3,
    K_BLD  = 3'd4,
    K_BRC  = 3'd5,
    K_RJMP = 3'd6,
    K_RSV  = 3'd7
  } op_kind_e;
endpackage

// File: rtl/flag_reg.sv
module flag_reg
  import flag_branch_pkg::*;
#(
  parameter int IDX_W = $clog2(SR_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic             bst_en,
  input  logic [IDX_W-1:0] idx,
  input  logic             t_src,
  output logic [SR_W-1:0]  sreg
);
  logic [SR_W-1:0] sreg_d;
  logic            sreg_en;

  always_comb begin
    sreg_d  = sreg;
    sreg_en = set_en | clr_en | bst_en;
    if (set_en)      sreg_d[idx]   = 1'b1;
    else if (clr_en) sreg_d[idx]   = 1'b0;
    else if (bst_en) sreg_d[FLG_T] = t_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sreg <= '0;
    else if (sreg_en) sreg <= sreg_d;
  end

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> sreg[$past(idx)] == 1'b1);
  assert_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> sreg[$past(idx)] == 1'b0);
  assert_bst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_en && !set_en && !clr_en) |=> sreg[FLG_T] == $past(t_src));
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en || clr_en || bst_en) |=> $stable(sreg));
endmodule

// File: rtl/branch_cond.sv
module branch_cond
  import flag_branch_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic [SR_W-1:0]  sreg,
  input  logic [SEL_W-1:0] sel,
  input  logic             pol,
  input  logic             uncond,
  output logic             taken
);
  logic cond_bit;

  always_comb begin
    if (sel[SEL_W-1]) cond_bit = sreg[FLG_N] ^ sreg[FLG_V];
    else              cond_bit = sreg[sel[2:0]];
    taken = uncond | (cond_bit == pol);
  end
endmodule

// File: rtl/target_calc.sv
module target_calc #(
  parameter int PC_W  = 16,
  parameter int BR_W  = 7,
  parameter int JMP_W = 12
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [JMP_W-1:0] ofs,
  input  logic             is_jump,
  input  logic             taken,
  output logic [PC_W-1:0]  target
);
  logic [PC_W-1:0] br_ext;
  logic [PC_W-1:0] jmp_ext;
  logic [PC_W-1:0] step;

  generate
    if (PC_W > JMP_W) begin : g_jwide
      assign jmp_ext = {{(PC_W-JMP_W){ofs[JMP_W-1]}}, ofs};
    end else begin : g_jtrim
      assign jmp_ext = ofs[PC_W-1:0];
    end
    if (PC_W > BR_W) begin : g_bwide
      assign br_ext = {{(PC_W-BR_W){ofs[BR_W-1]}}, ofs[BR_W-1:0]};
    end else begin : g_btrim
      assign br_ext = ofs[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    if (!taken)       step = '0;
    else if (is_jump) step = jmp_ext;
    else              step = br_ext;
    target = pc + step + {{(PC_W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
  import flag_branch_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int BR_W   = 7,
  parameter int JMP_W  = 12,
  parameter int DATA_W = 8,
  parameter int BIT_W  = $clog2(DATA_W),
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_kind,
  input  logic [BIT_W-1:0]  op_bit,
  input  logic [SEL_W-1:0]  op_sel,
  input  logic              op_pol,
  input  logic [DATA_W-1:0] reg_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [JMP_W-1:0]  ofs_in,
  output logic [7:0]        sreg,
  output logic [DATA_W-1:0] reg_out,
  output logic              br_valid,
  output logic              br_taken,
  output logic [1:0]        br_cycles,
  output logic [PC_W-1:0]   br_pc
);
  localparam int IDX_W = $clog2(SR_W);

  op_kind_e        kind;
  logic            is_set, is_clr, is_bst, is_brc, is_jmp, is_any_br;
  logic            taken_c;
  logic [PC_W-1:0] target_c;

  assign kind      = op_kind_e'(op_kind);
  assign is_set    = op_valid && (kind == K_FSET);
  assign is_clr    = op_valid && (kind == K_FCLR);
  assign is_bst    = op_valid && (kind == K_BST);
  assign is_brc    = op_valid && (kind == K_BRC);
  assign is_jmp    = op_valid && (kind == K_RJMP);
  assign is_any_br = is_brc | is_jmp;

  flag_reg #(.IDX_W(IDX_W)) flags_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (is_set),
    .clr_en (is_clr),
    .bst_en (is_bst),
    .idx    (op_bit[IDX_W-1:0]),
    .t_src  (reg_in[op_bit]),
    .sreg   (sreg)
  );

  branch_cond #(.SEL_W(SEL_W)) cond_i (
    .sreg   (sreg),
    .sel    (op_sel),
    .pol    (op_pol),
    .uncond (is_jmp),
    .taken  (taken_c)
  );

  target_calc #(.PC_W(PC_W), .BR_W(BR_W), .JMP_W(JMP_W)) tgt_i (
    .pc      (pc_in),
    .ofs     (ofs_in),
    .is_jump (is_jmp),
    .taken   (taken_c),
    .target  (target_c)
  );

  always_comb begin
    reg_out         = reg_in;
    reg_out[op_bit] = sreg[FLG_T];
  end

  logic            br_valid_d, br_taken_d;
  logic [1:0]      br_cycles_d;
  logic [PC_W-1:0] br_pc_d;

  always_comb begin
    br_valid_d  = is_any_br;
    br_taken_d  = br_taken;
    br_cycles_d = br_cycles;
    br_pc_d     = br_pc;
    if (is_any_br) begin
      br_taken_d  = taken_c;
      br_cycles_d = taken_c ? 2'd2 : 2'd1;
      br_pc_d     = target_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_valid  <= 1'b0;
      br_taken  <= 1'b0;
      br_cycles <= 2'd0;
      br_pc     <= '0;
    end else begin
      br_valid <= br_valid_d;
      if (is_any_br) begin
        br_taken  <= br_taken_d;
        br_cycles <= br_cycles_d;
        br_pc     <= br_pc_d;
      end
    end
  end

  assert_jump_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_jmp |=> (br_taken && br_cycles == 2'd2));
  assert_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    is_any_br |=> br_valid);
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !is_any_br |=> !br_valid);
  assert_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    is_any_br |=> $stable(sreg));
  assert_cycles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |-> (br_cycles == (br_taken ? 2'd2 : 2'd1)));
  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_brc && !taken_c) |=> br_pc == $past(pc_in) + 1'b1);
endmodule

// File: tb/flag_branch_unit_tb_top.sv
module flag_branch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_kind;
  logic [2:0]  op_bit;
  logic [3:0]  op_sel;
  logic        op_pol;
  logic [7:0]  reg_in;
  logic [15:0] pc_in;
  logic [11:0] ofs_in;
  logic [7:0]  sreg;
  logic [7:0]  reg_out;
  logic        br_valid, br_taken;
  logic [1:0]  br_cycles;
  logic [15:0] br_pc;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  flag_branch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_bit(op_bit), .op_sel(op_sel), .op_pol(op_pol), .reg_in(reg_in),
    .pc_in(pc_in), .ofs_in(ofs_in), .sreg(sreg), .reg_out(reg_out),
    .br_valid(br_valid), .br_taken(br_taken), .br_cycles(br_cycles), .br_pc(br_pc)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic do_op(input logic [2:0] k, input logic [2:0] b, input logic [3:0] s,
                       input logic p, input logic [7:0] r, input logic [15:0] pc,
                       input logic [11:0] o);
    op_valid = 1'b1; op_kind = k; op_bit = b; op_sel = s; op_pol = p;
    reg_in = r; pc_in = pc; ofs_in = o;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic load_flags(input logic [7:0] v);
    for (int b = 0; b < 8; b++)
      do_op(v[b] ? 3'd1 : 3'd2, 3'(b), 4'd0, 1'b0, 8'h00, 16'h0, 12'h0);
  endtask

  function automatic int sext(input int val, input int w);
    int m;
    m = val & ((1 << w) - 1);
    if (m >= (1 << (w - 1))) m = m - (1 << w);
    return m;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R11 actual=%0h expected=%0h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] expv;
    logic [7:0] rv;
    logic [15:0] pcv, exp_pc;
    logic [11:0] ov;
    bit exp_t;
    rst_n = 1'b0; op_valid = 1'b0; op_kind = 3'd0; op_bit = 3'd0; op_sel = 4'd0;
    op_pol = 1'b0; reg_in = 8'h00; pc_in = 16'h0; ofs_in = 12'h0;
    repeat (3) @(negedge clk);
    chk(sreg == 8'h00, "R1 sreg reset", sreg, 0);
    chk(br_valid == 1'b0, "R1 br_valid reset", br_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 256; v++) begin
      load_flags(8'(v));
      chk(sreg == 8'(v), "R2 R3 flag set/clear build", sreg, v);
      // single set and clear on a rotating index
      expv = 8'(v) | (8'h01 << (v % 8));
      do_op(3'd1, 3'(v % 8), 4'd0, 1'b0, 8'h00, 16'h0, 12'h0);
      chk(sreg == expv, "R2 flag set", sreg, expv);
      expv = 8'(v) & ~(8'h01 << (v % 8));
      do_op(3'd2, 3'(v % 8), 4'd0, 1'b0, 8'h00, 16'h0, 12'h0);
      chk(sreg == expv, "R3 flag clear", sreg, expv);
      load_flags(8'(v));
      for (int s = 0; s < 9; s++) begin
        for (int p = 0; p < 2; p++) begin
          pcv = 16'(v * 263 + s * 4099 + p * 31 + 16'hFFC0);
          ov  = 12'(v * 37 + s * 211 + p * 1000);
          do_op(3'd5, 3'd0, 4'(s), 1'(p), 8'h00, pcv, ov);
          if (s == 8) exp_t = ((v >> 2 & 1) ^ (v >> 3 & 1)) == p;
          else        exp_t = ((v >> s) & 1) == p;
          exp_pc = exp_t ? 16'(int'(pcv) + sext(int'(ov), 7) + 1) : 16'(pcv + 1);
          if (s == 8) chk(br_taken == exp_t, "R7 signed condition", br_taken, exp_t);
          else        chk(br_taken == exp_t, "R6 flag condition", br_taken, exp_t);
          chk(br_valid == 1'b1, "R11 branch valid", br_valid, 1);
          chk(br_pc == exp_pc, "R8 branch target", br_pc, exp_pc);
          chk(br_cycles == (exp_t ? 2'd2 : 2'd1), "R9 branch cycles", br_cycles, exp_t ? 2 : 1);
          chk(sreg == 8'(v), "R11 branch keeps flags", sreg, v);
        end
      end
      // unconditional jump with 12-bit offset
      pcv = 16'(v * 977);
      ov  = 12'(v * 16 + 12'h80F);
      do_op(3'd6, 3'd0, 4'd0, 1'b0, 8'h00, pcv, ov);
      exp_pc = 16'(int'(pcv) + sext(int'(ov), 12) + 1);
      chk(br_taken && br_cycles == 2'd2, "R10 jump taken two cycles", {br_taken, br_cycles}, 3'b110);
      chk(br_pc == exp_pc, "R10 jump target", br_pc, exp_pc);
      // idle and reserved kinds leave flags alone, br_valid drops
      op_valid = 1'b0; op_kind = 3'd1; op_bit = 3'(~v);
      @(negedge clk);
      chk(sreg == 8'(v), "R12 no valid holds", sreg, v);
      chk(br_valid == 1'b0, "R11 valid drops", br_valid, 0);
      do_op(3'd7, 3'(v), 4'd0, 1'b0, 8'hFF, 16'h0, 12'h0);
      chk(sreg == 8'(v), "R12 reserved kind holds", sreg, v);
      do_op(3'd0, 3'(v), 4'd0, 1'b0, 8'hFF, 16'h0, 12'h0);
      chk(sreg == 8'(v), "R12 nop kind holds", sreg, v);
      // bit load: T replaces the chosen bit, flags unchanged
      rv = 8'(v * 73 + 5);
      op_bit = 3'(v + 3); reg_in = rv; op_kind = 3'd4; op_valid = 1'b1;
      #1;
      expv = (rv & ~(8'h01 << ((v + 3) % 8))) | (8'(v >> 6 & 1) << ((v + 3) % 8));
      chk(reg_out == expv, "R5 bit load output", reg_out, expv);
      @(negedge clk);
      op_valid = 1'b0;
      chk(sreg == 8'(v), "R5 bit load keeps flags", sreg, v);
      // bit store: chosen bit differs from current T
      rv = ((v >> 6) & 1) ? ~(8'h01 << (v % 8)) : (8'h01 << (v % 8));
      do_op(3'd3, 3'(v % 8), 4'd0, 1'b0, rv, 16'h0, 12'h0);
      expv = 8'(v) ^ 8'h40;
      chk(sreg == expv, "R4 bit store into T", sreg, expv);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule